// File: doc/BRIEF.md
# SPI Master Transfer Sequencer with Chip-Select Mapping

This block sits between the transmit side of an SPI controller and its serial shift engine. It decides when a queued word may go out, drives the four chip-select lines for that transfer, and tells the shift engine which of four per-select format registers to use. The mode inputs set its behaviour. They select master or slave operation, a fixed select code or one that comes with each word, and direct or externally decoded chip selects. They also turn mode-fault detection on or off, enable holding off transfers until received data is read, and enable internal loopback.

The transmitter offers a word with `tx_valid`, and the block accepts it when `tx_ready` is high in the same cycle. On acceptance the block registers the chip-select code, the format-register index and the data, and pulses `shift_start`. When the shift engine pulses `shift_done`, the chip selects return to all ones and the received word goes into a one-word receive holding register. The block raises a sticky overrun flag if that register still holds an unread word. If the external slave-select input is driven low while the block is master, a sticky mode-fault flag is set, and it blocks new transfers until it is cleared.

Top module: `spi_xfer_ctrl`

## Requirements
- R1: After reset, `cs_n` is 4'b1111, `shift_start`, `rx_full`, `overrun` and `mode_fault` are 0.
- R2: With `cfg_master`=0, `tx_ready` is 0 and no transfer starts.
- R3: With `cfg_var_sel`=1 the select code is `tx_sel`; with 0 it is `cfg_fixed_sel`.
- R4: With `cfg_decode`=1, `cs_n` carries the select code as a binary value during the transfer, and `cfg_idx` equals bits [3:2] of the code (codes 0–3 give index 0, 4–7 give 1, 8–11 give 2, 12–14 give 3).
- R5: With `cfg_decode`=1 and code 4'b1111, no peripheral is selected: `cs_n` stays 4'b1111 during the transfer and `cfg_idx` is 3.
- R6: With `cfg_decode`=0, `cs_n` is the select code as active-low lines, and `cfg_idx` is the position of the lowest 0 bit in the code, or 3 if the code has no 0 bit.
- R7: The cycle after an accepted word, `shift_start` is 1 for one cycle and `shift_data` holds the word. The cycle after `shift_done`, `cs_n` is back at 4'b1111.
- R8: With `cfg_wait_read`=1 and `rx_full`=1, `tx_ready` is 0 and no transfer starts.
- R9: With `cfg_wait_read`=0, a master transfer starts even while `rx_full`=1.
- R10: In master mode with `cfg_fault_off`=0, a low `ss_n_in` sets `mode_fault` on the next edge. While it is set, `tx_ready` is 0. `fault_clr` clears it once `ss_n_in` is high.
- R11: With `cfg_fault_off`=1, a low `ss_n_in` leaves `mode_fault` at 0.
- R12: On `shift_done`, `rx_data` takes `shift_rx_data` and `rx_full` is set. If `rx_full` was already 1 and `rx_read` is low, `overrun` is set. `overrun_clr` clears it.
- R13: `sdi_out` equals `sdo_in` when `cfg_loopback`=1 and `miso_in` when 0.
- R14: `rx_read` clears `rx_full` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_var_sel | input | 1 | 1 = select code comes with each word |
| cfg_decode | input | 1 | 1 = chip selects drive an external 4-to-16 decoder |
| cfg_fault_off | input | 1 | 1 = mode-fault detection disabled |
| cfg_wait_read | input | 1 | 1 = hold off transfers while receive data is unread |
| cfg_loopback | input | 1 | 1 = serial output looped to serial input |
| cfg_fixed_sel | input | 4 | Fixed select code |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Word accepted this cycle if valid |
| tx_data | input | DATA_W | Transmit word |
| tx_sel | input | 4 | Per-word select code |
| shift_start | output | 1 | One-cycle start pulse to the shift engine |
| shift_data | output | DATA_W | Word for the shift engine |
| cfg_idx | output | 2 | Format-register index for the transfer |
| shift_done | input | 1 | Shift engine finished the transfer |
| shift_rx_data | input | DATA_W | Word received by the shift engine |
| cs_n | output | 4 | Chip-select lines |
| ss_n_in | input | 1 | External slave-select input |
| sdo_in | input | 1 | Serial output from the shift engine |
| miso_in | input | 1 | Serial data from the pad |
| sdi_out | output | 1 | Serial data into the shift engine |
| rx_read | input | 1 | Receive word consumed |
| rx_data | output | DATA_W | Receive holding register |
| rx_full | output | 1 | Receive holding register has unread data |
| overrun | output | 1 | Sticky receive overrun flag |
| overrun_clr | input | 1 | Clears `overrun` |
| mode_fault | output | 1 | Sticky mode-fault flag |
| fault_clr | input | 1 | Clears `mode_fault` |

## Verification
Assertions check four things on every cycle. A start pulse never follows a cycle spent in slave mode, with the mode fault set, or with the wait-for-read hold active. The chip selects are idle right after a completion. Overrun only rises when a word lands on unread data. Disabled fault detection never raises the flag. The bench's scenarios cover the rest: the mapping from select code to chip-select lines and format index in both decode modes, including the no-select code, the choice between fixed and per-word codes, the received data value, the clear inputs and the loopback path.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
    localparam int SEL_W = 4;
    localparam int IDX_W = 2;
    localparam logic [SEL_W-1:0] CS_IDLE = '1;

    typedef struct packed {
        logic             master;
        logic             var_sel;
        logic             decode;
        logic             fault_off;
        logic             wait_read;
        logic             loopback;
        logic [SEL_W-1:0] fixed_sel;
    } mode_t;

    typedef enum logic {ST_IDLE, ST_BUSY} xfer_st_e;

    typedef struct packed {
        logic [SEL_W-1:0] cs_code;
        logic [IDX_W-1:0] idx;
    } sel_map_t;

    // Position of the lowest active-low line; top index when none is low.
    function automatic logic [IDX_W-1:0] lowest_low(input logic [SEL_W-1:0] c);
        logic [IDX_W-1:0] r;
        r = IDX_W'(SEL_W - 1);
        for (int i = SEL_W - 1; i >= 0; i--) begin
            if (!c[i]) r = IDX_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/spi_sel_map.sv
module spi_sel_map
    import spi_xfer_pkg::*;
(
    input  logic             decode,
    input  logic [SEL_W-1:0] sel,
    output sel_map_t         map
);
    always_comb begin
        map.cs_code = sel;
        if (decode) map.idx = sel[SEL_W-1 -: IDX_W];
        else        map.idx = lowest_low(sel);
    end
endmodule

// File: rtl/spi_fault_mon.sv
module spi_fault_mon (
    input  logic clk,
    input  logic rst,
    input  logic master,
    input  logic fault_off,
    input  logic ss_n,
    input  logic clr,
    output logic fault
);
    logic set_now;
    assign set_now = master && !fault_off && !ss_n;

    always_ff @(posedge clk) begin
        if (rst) fault <= 1'b0;
        else     fault <= set_now || (fault && !clr);
    end

    // R11: detection disabled never raises a fresh fault
    assert_fault_off_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        ($past(fault_off) && !$past(fault)) |-> !fault);
endmodule

// File: rtl/spi_rx_hold.sv
module spi_rx_hold #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              rd,
    input  logic              ovr_clr,
    output logic [DATA_W-1:0] dout,
    output logic              full,
    output logic              ovr
);
    logic ovr_set;
    assign ovr_set = load && full && !rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
            full <= 1'b0;
            ovr  <= 1'b0;
        end else begin
            ovr <= ovr_set || (ovr && !ovr_clr);
            if (load) begin
                dout <= din;
                full <= 1'b1;
            end else if (rd) begin
                full <= 1'b0;
            end
        end
    end

    // R12: overrun only rises when a word lands on unread data
    assert_overrun_cause_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> ($past(full) && $past(load)));
endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
    import spi_xfer_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_master,
    input  logic              cfg_var_sel,
    input  logic              cfg_decode,
    input  logic              cfg_fault_off,
    input  logic              cfg_wait_read,
    input  logic              cfg_loopback,
    input  logic [3:0]        cfg_fixed_sel,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [3:0]        tx_sel,
    output logic              shift_start,
    output logic [DATA_W-1:0] shift_data,
    output logic [1:0]        cfg_idx,
    input  logic              shift_done,
    input  logic [DATA_W-1:0] shift_rx_data,
    output logic [3:0]        cs_n,
    input  logic              ss_n_in,
    input  logic              sdo_in,
    input  logic              miso_in,
    output logic              sdi_out,
    input  logic              rx_read,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              overrun,
    input  logic              overrun_clr,
    output logic              mode_fault,
    input  logic              fault_clr
);
    mode_t            mode;
    xfer_st_e         st;
    logic [SEL_W-1:0] sel;
    sel_map_t         map;
    logic             can_start, accept;

    assign mode = '{master: cfg_master, var_sel: cfg_var_sel, decode: cfg_decode,
                    fault_off: cfg_fault_off, wait_read: cfg_wait_read,
                    loopback: cfg_loopback, fixed_sel: cfg_fixed_sel};

    assign sel = mode.var_sel ? tx_sel : mode.fixed_sel;

    spi_sel_map u_map (.decode(mode.decode), .sel(sel), .map(map));

    spi_fault_mon u_fault (
        .clk(clk), .rst(rst), .master(mode.master), .fault_off(mode.fault_off),
        .ss_n(ss_n_in), .clr(fault_clr), .fault(mode_fault)
    );

    spi_rx_hold #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst(rst), .load(shift_done), .din(shift_rx_data),
        .rd(rx_read), .ovr_clr(overrun_clr), .dout(rx_data),
        .full(rx_full), .ovr(overrun)
    );

    assign can_start = (st == ST_IDLE) && mode.master && !mode_fault
                       && !(mode.wait_read && rx_full);
    assign tx_ready  = can_start;
    assign accept    = tx_valid && can_start;
    assign sdi_out   = mode.loopback ? sdo_in : miso_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            cs_n        <= CS_IDLE;
            cfg_idx     <= '0;
            shift_start <= 1'b0;
            shift_data  <= '0;
        end else begin
            shift_start <= 1'b0;
            if (accept) begin
                st          <= ST_BUSY;
                cs_n        <= map.cs_code;
                cfg_idx     <= map.idx;
                shift_start <= 1'b1;
                shift_data  <= tx_data;
            end else if (st == ST_BUSY && shift_done) begin
                st   <= ST_IDLE;
                cs_n <= CS_IDLE;
            end
        end
    end

    // R2: no start follows a slave-mode cycle
    assert_slave_no_start_R2: assert property (@(posedge clk) disable iff (rst)
        shift_start |-> $past(cfg_master));
    // R8: no start while unread data blocks it
    assert_wait_read_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (shift_start && $past(cfg_wait_read)) |-> !$past(rx_full));
    // R10: a pending mode fault blocks starts
    assert_fault_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        shift_start |-> !$past(mode_fault));
    // R7: chip selects idle right after a completion
    assert_cs_release_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(shift_done) && !$past(shift_start)) |-> (cs_n == CS_IDLE));
endmodule

// File: tb/spi_xfer_ctrl_test.sv
`timescale 1ns/1ps
module spi_xfer_ctrl_test;
    logic clk = 1'b0, rst = 1'b1;
    logic cfg_master = 0, cfg_var_sel = 0, cfg_decode = 0, cfg_fault_off = 0;
    logic cfg_wait_read = 0, cfg_loopback = 0;
    logic [3:0] cfg_fixed_sel = 4'hF;
    logic tx_valid = 0, tx_ready;
    logic [15:0] tx_data = 0, shift_data, shift_rx_data = 0, rx_data;
    logic [3:0] tx_sel = 4'hF, cs_n;
    logic shift_start, shift_done = 0;
    logic [1:0] cfg_idx;
    logic ss_n_in = 1, sdo_in = 0, miso_in = 0, sdi_out;
    logic rx_read = 0, rx_full, overrun, overrun_clr = 0, mode_fault, fault_clr = 0;
    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    spi_xfer_ctrl uut (.*);

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_idx(input logic dec, input logic [3:0] s);
        if (dec) return s[3:2];
        for (int i = 0; i < 4; i++) if (!s[i]) return 2'(i);
        return 2'd3;
    endfunction

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic run_xfer(input logic [15:0] d, input logic [3:0] s, input logic [15:0] rv);
        logic [3:0] es;
        es = cfg_var_sel ? s : cfg_fixed_sel;
        tx_data = d; tx_sel = s; tx_valid = 1;
        #0.5;
        chk(tx_ready === 1'b1, "R9 tx_ready when idle", tx_ready, 1);
        tick(); tx_valid = 0;
        chk(shift_start === 1'b1, "R7 start pulse", shift_start, 1);
        chk(shift_data === d, "R7 shift data", shift_data, d);
        chk(cs_n === es, cfg_decode ? (es == 4'hF ? "R5 no-select code" : "R4 decode code")
                                   : "R6 direct code", cs_n, es);
        chk(cfg_idx === exp_idx(cfg_decode, es), cfg_var_sel ? "R3 var idx" : "R3 fixed idx",
            cfg_idx, exp_idx(cfg_decode, es));
        tick();
        chk(shift_start === 1'b0, "R7 pulse one cycle", shift_start, 0);
        shift_done = 1; shift_rx_data = rv;
        tick(); shift_done = 0;
        chk(cs_n === 4'hF, "R7 cs release", cs_n, 4'hF);
        chk(rx_full === 1'b1 && rx_data === rv, "R12 rx capture", rx_data, rv);
    endtask

    task automatic read_rx();
        rx_read = 1; tick(); rx_read = 0;
        chk(rx_full === 1'b0, "R14 read clears full", rx_full, 0);
    endtask

    initial begin
        #1_000_000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) tick();
        rst = 0; tick();
        // R1 reset state
        chk(cs_n === 4'hF, "R1 cs idle", cs_n, 4'hF);
        chk(!shift_start && !rx_full && !overrun && !mode_fault, "R1 flags clear",
            {shift_start, rx_full, overrun, mode_fault}, 0);
        // R2 slave mode
        tx_valid = 1; #0.5;
        chk(tx_ready === 1'b0, "R2 slave not ready", tx_ready, 0);
        tick(); tx_valid = 0;
        chk(shift_start === 1'b0 && cs_n === 4'hF, "R2 slave no start", shift_start, 0);
        cfg_master = 1;
        // directed: decode no-select code, direct all-ones, fixed select
        cfg_decode = 1; cfg_var_sel = 1;
        run_xfer(16'h1111, 4'hF, 16'hA001); read_rx();
        cfg_decode = 0;
        run_xfer(16'h2222, 4'hF, 16'hA002); read_rx();
        cfg_var_sel = 0; cfg_fixed_sel = 4'b1011;
        run_xfer(16'h3333, 4'h0, 16'hA003); read_rx();
        // random mix
        for (int n = 0; n < 40; n++) begin
            cfg_decode = 1'($urandom); cfg_var_sel = 1'($urandom);
            cfg_fixed_sel = 4'($urandom);
            run_xfer(16'($urandom), 4'($urandom), 16'($urandom));
            read_rx();
        end
        // R8 wait-for-read hold
        cfg_var_sel = 1; cfg_decode = 1;
        run_xfer(16'h4444, 4'h5, 16'hB001);
        cfg_wait_read = 1; tx_valid = 1; #0.5;
        chk(tx_ready === 1'b0, "R8 held while full", tx_ready, 0);
        tick(); tx_valid = 0;
        chk(shift_start === 1'b0, "R8 no start", shift_start, 0);
        // R9 start regardless, then R12 overrun
        cfg_wait_read = 0;
        run_xfer(16'h5555, 4'h9, 16'hB002);
        chk(overrun === 1'b1, "R12 overrun set", overrun, 1);
        overrun_clr = 1; tick(); overrun_clr = 0;
        chk(overrun === 1'b0, "R12 overrun clear", overrun, 0);
        read_rx();
        // R10 mode fault
        ss_n_in = 0; tick(); ss_n_in = 1;
        chk(mode_fault === 1'b1, "R10 fault set", mode_fault, 1);
        tx_valid = 1; #0.5;
        chk(tx_ready === 1'b0, "R10 fault blocks", tx_ready, 0);
        tick(); tx_valid = 0;
        chk(shift_start === 1'b0, "R10 no start", shift_start, 0);
        fault_clr = 1; tick(); fault_clr = 0;
        chk(mode_fault === 1'b0, "R10 fault cleared", mode_fault, 0);
        // R11 detection off
        cfg_fault_off = 1; ss_n_in = 0; tick(); tick(); ss_n_in = 1;
        chk(mode_fault === 1'b0, "R11 fault ignored", mode_fault, 0);
        // R13 loopback
        cfg_loopback = 1; sdo_in = 1; miso_in = 0; #0.5;
        chk(sdi_out === 1'b1, "R13 loopback on", sdi_out, 1);
        sdo_in = 0; miso_in = 1; #0.5;
        chk(sdi_out === 1'b0, "R13 pad ignored", sdi_out, 0);
        cfg_loopback = 0; #0.5;
        chk(sdi_out === 1'b1, "R13 loopback off", sdi_out, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule